// File: doc/BRIEF.md
# Stall-Aware Posted Write Holder

This block forwards CPU memory writes onto a memory-master port facing a PCI target, and it copes with a target that can raise a stall line. While the stall is low, each accepted CPU write goes out on the master port one cycle later. The outgoing byte address is formed by placing a window base value above a fixed bit position and merging it with the CPU word offset scaled to bytes.

The stall line is registered every cycle. While the registered stall state is 1, the next accepted CPU write is not sent. Its offset, data and byte mask are parked in a single holding slot, and the CPU is held off with a wait signal. When the stall returns to 0, the parked write is replayed from the slot. The CPU is released in the cycle the master port accepts the replay. Each 1-to-0 stall transition also emits a one-cycle pulse that clears a retry counter shared with other masters.

Top module: `stall_posted_writer`

## Requirements
- R1: The master byte address equals `win_base` shifted left by 21 bits, ORed with `cpu_wr_offset` shifted left by 2 bits. `win_base` is taken at the cycle the write is loaded onto the master port.
- R2: A write is accepted when `cpu_wr_valid` is 1 and `cpu_wait` is 0. If the registered stall state is 0 when it is accepted, the write appears on `m_valid`/`m_addr`/`m_data`/`m_mask` in the next cycle. In that case `cpu_wait` stays 0 when `m_ready` is 1.
- R3: A write accepted while both the registered stall state and `tgt_stall` are 1 is not presented on the master port for as long as the stall remains.
- R4: From the cycle after such a capture until the replay is accepted, `cpu_wait` is 1, and further CPU writes are not accepted.
- R5: At a stall fall (registered state 1, `tgt_stall` 0), a held write is presented in the next cycle with its saved address, data and mask.
- R6: `cpu_wait` returns to 0 in the cycle in which the replayed write has `m_valid` and `m_ready` both at 1.
- R7: `retry_clr` is 1 for exactly the one cycle after every stall fall, whether or not a write is held.
- R8: A stall fall with no held write and no CPU write presents nothing on the master port.
- R9: A write accepted in the same cycle as a stall fall, or in the first cycle that `tgt_stall` rises (registered state still 0), is sent directly.
- R10: While `m_valid` is 1 and `m_ready` is 0, the address, data and mask stay stable, and `cpu_wait` is 1.
- R11: After reset, `m_valid`, `cpu_wait` and `retry_clr` are 0, and the registered stall state, slot flag and saved contents are cleared.
- R12: Writes leave the master port in the order in which the CPU side accepted them, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base | input | ADDR_W-BASE_SHIFT | Window base value |
| cpu_wr_valid | input | 1 | CPU write request |
| cpu_wr_offset | input | ADDR_W-2 | CPU word offset |
| cpu_wr_data | input | DATA_W | CPU write data |
| cpu_wr_mask | input | DATA_W/8 | CPU byte enables |
| cpu_wait | output | 1 | CPU hold; a write is taken only when low |
| tgt_stall | input | 1 | Target stall line |
| retry_clr | output | 1 | One-cycle pulse after each stall fall |
| m_valid | output | 1 | Master write valid |
| m_addr | output | ADDR_W | Master byte address |
| m_data | output | DATA_W | Master write data |
| m_mask | output | DATA_W/8 | Master byte enables |
| m_ready | input | 1 | Master port accepts the write |

## Verification
Directed sequences exercise the cases that separate the three issue paths.
- A write with the stall low, and one in the first cycle of a rising stall, must both go out at once.
- A write under a settled stall must stay parked through several cycles and reappear only after the fall.
- A write coinciding with the fall must bypass the slot.

A fall with nothing held separates the retry pulse from any replay. Holding `m_ready` low during a replay separates the release rule from the fall itself. Long random runs toggle the stall, throttle `m_ready` and keep CPU requests pending, and a scoreboard confirms the order and that no parked write escapes before its stall ends.

// File: rtl/pwh_pkg.sv
package pwh_pkg;

   typedef enum logic [1:0] {
      ISSUE_IDLE   = 2'd0,
      ISSUE_DIRECT = 2'd1,
      ISSUE_REPLAY = 2'd2
   } issue_e;

endpackage

// File: rtl/pwh_stall_track.sv
module pwh_stall_track (
   input  logic clk,
   input  logic rst_n,
   input  logic stall_in,
   output logic stall_q,
   output logic stall_fall,
   output logic retry_clr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q   <= 1'b0;
         retry_clr <= 1'b0;
      end else begin
         stall_q   <= stall_in;
         retry_clr <= stall_fall;
      end
   end

   assign stall_fall = stall_q & ~stall_in;

endmodule

// File: rtl/pwh_hold_slot.sv
module pwh_hold_slot #(
   parameter int OFS_W  = 30,
   parameter int DATA_W = 32,
   parameter int MASK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              release_i,
   input  logic [OFS_W-1:0]  in_ofs,
   input  logic [DATA_W-1:0] in_data,
   input  logic [MASK_W-1:0] in_mask,
   output logic              held,
   output logic [OFS_W-1:0]  s_ofs,
   output logic [DATA_W-1:0] s_data,
   output logic [MASK_W-1:0] s_mask
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held   <= 1'b0;
         s_ofs  <= '0;
         s_data <= '0;
         s_mask <= '0;
      end else begin
         if (capture) begin
            held   <= 1'b1;
            s_ofs  <= in_ofs;
            s_data <= in_data;
            s_mask <= in_mask;
         end else if (release_i) begin
            held <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pwh_addr_form.sv
module pwh_addr_form #(
   parameter int ADDR_W     = 32,
   parameter int BASE_SHIFT = 21,
   parameter int WORD_SHIFT = 2,
   parameter int JOIN_ADD   = 0,
   localparam int BASE_W    = ADDR_W - BASE_SHIFT,
   localparam int OFS_W     = ADDR_W - WORD_SHIFT
) (
   input  logic [BASE_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] base_ext;
   logic [ADDR_W-1:0] ofs_ext;

   assign base_ext = {base, {BASE_SHIFT{1'b0}}};
   assign ofs_ext  = {ofs, {WORD_SHIFT{1'b0}}};

   generate
      if (JOIN_ADD != 0) begin : g_add
         assign addr = base_ext + ofs_ext;
      end else begin : g_or
         assign addr = base_ext | ofs_ext;
      end
   endgenerate

endmodule

// File: rtl/pwh_out_stage.sv
module pwh_out_stage #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int MASK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [MASK_W-1:0] in_mask,
   input  logic              ready,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic [MASK_W-1:0] mask
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
         mask  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         addr  <= in_addr;
         data  <= in_data;
         mask  <= in_mask;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/stall_posted_writer.sv
module stall_posted_writer #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int BASE_SHIFT = 21,
   parameter int JOIN_ADD   = 0,
   localparam int MASK_W     = DATA_W / 8,
   localparam int WORD_SHIFT = $clog2(MASK_W),
   localparam int BASE_W     = ADDR_W - BASE_SHIFT,
   localparam int OFS_W      = ADDR_W - WORD_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] win_base,
   input  logic              cpu_wr_valid,
   input  logic [OFS_W-1:0]  cpu_wr_offset,
   input  logic [DATA_W-1:0] cpu_wr_data,
   input  logic [MASK_W-1:0] cpu_wr_mask,
   output logic              cpu_wait,
   input  logic              tgt_stall,
   output logic              retry_clr,
   output logic              m_valid,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_data,
   output logic [MASK_W-1:0] m_mask,
   input  logic              m_ready
);
   import pwh_pkg::*;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (BASE_SHIFT <= WORD_SHIFT || BASE_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("BASE_SHIFT must lie above the word shift and below ADDR_W");
      end
   endgenerate

   logic              stall_q;
   logic              stall_fall;
   logic              hold_flag;
   logic [OFS_W-1:0]  s_ofs;
   logic [DATA_W-1:0] s_data;
   logic [MASK_W-1:0] s_mask;
   logic              out_busy;
   logic              cpu_acc;
   logic              capture;
   logic              direct;
   logic              replay;
   issue_e            issue_sel;
   logic [OFS_W-1:0]  sel_ofs;
   logic [DATA_W-1:0] sel_data;
   logic [MASK_W-1:0] sel_mask;
   logic [ADDR_W-1:0] sel_addr;
   logic              load;

   pwh_stall_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall_in   (tgt_stall),
      .stall_q    (stall_q),
      .stall_fall (stall_fall),
      .retry_clr  (retry_clr)
   );

   assign out_busy = m_valid & ~m_ready;
   assign cpu_wait = hold_flag | out_busy;
   assign cpu_acc  = cpu_wr_valid & ~cpu_wait;
   assign capture  = cpu_acc & stall_q & tgt_stall;
   assign direct   = cpu_acc & ~(stall_q & tgt_stall);
   assign replay   = hold_flag & stall_fall;

   pwh_hold_slot #(
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W),
      .MASK_W (MASK_W)
   ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .release_i (replay),
      .in_ofs    (cpu_wr_offset),
      .in_data   (cpu_wr_data),
      .in_mask   (cpu_wr_mask),
      .held      (hold_flag),
      .s_ofs     (s_ofs),
      .s_data    (s_data),
      .s_mask    (s_mask)
   );

   always_comb begin
      if (replay)      issue_sel = ISSUE_REPLAY;
      else if (direct) issue_sel = ISSUE_DIRECT;
      else             issue_sel = ISSUE_IDLE;
   end

   always_comb begin
      unique case (issue_sel)
         ISSUE_REPLAY: begin
            sel_ofs  = s_ofs;
            sel_data = s_data;
            sel_mask = s_mask;
         end
         default: begin
            sel_ofs  = cpu_wr_offset;
            sel_data = cpu_wr_data;
            sel_mask = cpu_wr_mask;
         end
      endcase
   end

   assign load = (issue_sel != ISSUE_IDLE);

   pwh_addr_form #(
      .ADDR_W     (ADDR_W),
      .BASE_SHIFT (BASE_SHIFT),
      .WORD_SHIFT (WORD_SHIFT),
      .JOIN_ADD   (JOIN_ADD)
   ) u_addr (
      .base (win_base),
      .ofs  (sel_ofs),
      .addr (sel_addr)
   );

   pwh_out_stage #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MASK_W (MASK_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .in_addr (sel_addr),
      .in_data (sel_data),
      .in_mask (sel_mask),
      .ready   (m_ready),
      .valid   (m_valid),
      .addr    (m_addr),
      .data    (m_data),
      .mask    (m_mask)
   );

endmodule

// File: rtl/pwh_chk.sv
module pwh_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int MASK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tgt_stall,
   input logic              stall_q,
   input logic              held,
   input logic              cpu_wr_valid,
   input logic              cpu_wait,
   input logic [DATA_W-1:0] cpu_wr_data,
   input logic              retry_clr,
   input logic              m_valid,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DATA_W-1:0] m_data,
   input logic [MASK_W-1:0] m_mask
);

   // R2
   pass_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr_valid && !cpu_wait && !(stall_q && tgt_stall)
      |=> m_valid && (m_data == $past(cpu_wr_data)));

   // R3
   capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr_valid && !cpu_wait && stall_q && tgt_stall
      |=> !m_valid && cpu_wait);

   // R4
   held_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> cpu_wait);

   // R5
   slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held && stall_q && !tgt_stall |-> (!m_valid || m_ready));

   // R7
   retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retry_clr |-> !$past(tgt_stall) && $past(tgt_stall, 2));

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready
      |=> m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_mask));

   // R10
   busy_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |-> cpu_wait);

endmodule

bind stall_posted_writer pwh_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .MASK_W (MASK_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tgt_stall    (tgt_stall),
   .stall_q      (stall_q),
   .held         (hold_flag),
   .cpu_wr_valid (cpu_wr_valid),
   .cpu_wait     (cpu_wait),
   .cpu_wr_data  (cpu_wr_data),
   .retry_clr    (retry_clr),
   .m_valid      (m_valid),
   .m_ready      (m_ready),
   .m_addr       (m_addr),
   .m_data       (m_data),
   .m_mask       (m_mask)
);

// File: tb/stall_posted_writer_tb.sv
module stall_posted_writer_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [10:0] win_base;
   logic        cpu_wr_valid;
   logic [29:0] cpu_wr_offset;
   logic [31:0] cpu_wr_data;
   logic [3:0]  cpu_wr_mask;
   logic        cpu_wait;
   logic        tgt_stall;
   logic        retry_clr;
   logic        m_valid;
   logic [31:0] m_addr;
   logic [31:0] m_data;
   logic [3:0]  m_mask;
   logic        m_ready;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [31:0] q_addr[$];
   logic [31:0] q_data[$];
   logic [3:0]  q_mask[$];
   int          q_fc[$];
   int          fall_cnt = 0;
   bit          sq = 0;
   bit          acc_last = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stall_posted_writer u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .win_base      (win_base),
      .cpu_wr_valid  (cpu_wr_valid),
      .cpu_wr_offset (cpu_wr_offset),
      .cpu_wr_data   (cpu_wr_data),
      .cpu_wr_mask   (cpu_wr_mask),
      .cpu_wait      (cpu_wait),
      .tgt_stall     (tgt_stall),
      .retry_clr     (retry_clr),
      .m_valid       (m_valid),
      .m_addr        (m_addr),
      .m_data        (m_data),
      .m_mask        (m_mask),
      .m_ready       (m_ready)
   );

   function automatic logic [31:0] exp_addr(input logic [10:0] b, input logic [29:0] o);
      return {b, 21'b0} | {o, 2'b00};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic smp();
      #2;
   endtask

   task automatic drive_wr(input logic [29:0] o, input logic [31:0] d, input logic [3:0] m);
      cpu_wr_valid  = 1'b1;
      cpu_wr_offset = o;
      cpu_wr_data   = d;
      cpu_wr_mask   = m;
   endtask

   // scoreboard monitor, sampled 2 time units after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (!rst_n) begin
            sq = 0;
            acc_last = 0;
         end else begin
            bit acc;
            bit cap;
            acc = cpu_wr_valid && !cpu_wait;
            cap = acc && sq && tgt_stall;
            if (m_valid && m_ready) begin
               n_chk++;
               if (q_addr.size() == 0) begin
                  n_fail++;
                  $display("FAIL R12 unexpected write actual=%h expected=none", m_addr);
               end else begin
                  logic [31:0] ea;
                  logic [31:0] ed;
                  logic [3:0]  em;
                  int          fc;
                  ea = q_addr.pop_front();
                  ed = q_data.pop_front();
                  em = q_mask.pop_front();
                  fc = q_fc.pop_front();
                  if (m_addr !== ea || m_data !== ed || m_mask !== em) begin
                     n_fail++;
                     $display("FAIL R1 R12 actual=%h/%h/%h expected=%h/%h/%h",
                              m_addr, m_data, m_mask, ea, ed, em);
                  end
                  if (fc >= 0 && fall_cnt <= fc) begin
                     n_fail++;
                     $display("FAIL R3 sent before stall fell actual=%0d expected>%0d", fall_cnt, fc);
                  end
               end
            end
            if (acc) begin
               q_addr.push_back(exp_addr(win_base, cpu_wr_offset));
               q_data.push_back(cpu_wr_data);
               q_mask.push_back(cpu_wr_mask);
               q_fc.push_back(cap ? fall_cnt : -1);
            end
            if (sq && !tgt_stall) fall_cnt++;
            sq = tgt_stall;
            acc_last = acc;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1badc0de));
      rst_n = 0; win_base = 11'h5A5; cpu_wr_valid = 0; cpu_wr_offset = 0;
      cpu_wr_data = 0; cpu_wr_mask = 0; tgt_stall = 0; m_ready = 1;
      repeat (3) cyc();
      rst_n = 1;
      smp();
      // R11 reset state
      chk("R11 m_valid", 64'(m_valid), 64'd0);
      chk("R11 cpu_wait", 64'(cpu_wait), 64'd0);
      chk("R11 retry_clr", 64'(retry_clr), 64'd0);

      // R2 pass-through, R1 address
      cyc(); drive_wr(30'h123, 32'hDEADBEEF, 4'hF); smp();
      chk("R2 no wait", 64'(cpu_wait), 64'd0);
      cyc(); cpu_wr_valid = 0; smp();
      chk("R2 m_valid", 64'(m_valid), 64'd1);
      chk("R1 m_addr", 64'(m_addr), 64'(exp_addr(11'h5A5, 30'h123)));
      chk("R2 m_data", 64'(m_data), 64'hDEADBEEF);
      cyc(); smp();
      chk("R2 idle", 64'(m_valid), 64'd0);

      // R3/R4/R5/R6/R7 capture and replay
      cyc(); tgt_stall = 1;
      cyc(); drive_wr(30'h2AB, 32'h12345678, 4'h5); smp();
      chk("R3 accepted", 64'(cpu_wait), 64'd0);
      cyc(); drive_wr(30'h007, 32'hCAFEF00D, 4'hA); smp();
      chk("R3 not sent", 64'(m_valid), 64'd0);
      chk("R4 wait", 64'(cpu_wait), 64'd1);
      for (int i = 0; i < 4; i++) begin
         cyc(); smp();
         chk("R3 still parked", 64'(m_valid), 64'd0);
         chk("R4 still held", 64'(cpu_wait), 64'd1);
      end
      cyc(); tgt_stall = 0; smp();
      chk("R4 held at fall", 64'(cpu_wait), 64'd1);
      chk("R5 not yet", 64'(m_valid), 64'd0);
      cyc(); smp();
      chk("R5 replay valid", 64'(m_valid), 64'd1);
      chk("R5 replay addr", 64'(m_addr), 64'(exp_addr(11'h5A5, 30'h2AB)));
      chk("R5 replay data", 64'(m_data), 64'h12345678);
      chk("R5 replay mask", 64'(m_mask), 64'h5);
      chk("R7 pulse", 64'(retry_clr), 64'd1);
      chk("R6 released", 64'(cpu_wait), 64'd0);
      cyc(); cpu_wr_valid = 0; smp();
      chk("R12 next in order", 64'(m_data), 64'hCAFEF00D);
      chk("R7 pulse ends", 64'(retry_clr), 64'd0);
      cyc(); smp();
      chk("R12 drained", 64'(m_valid), 64'd0);

      // R6/R10 replay under backpressure
      cyc(); tgt_stall = 1;
      cyc(); drive_wr(30'h010, 32'h0BADF00D, 4'h3);
      cyc(); cpu_wr_valid = 0; m_ready = 0;
      cyc(); tgt_stall = 0;
      cyc(); smp();
      chk("R5 replay bp", 64'(m_data), 64'h0BADF00D);
      chk("R6 wait until accepted", 64'(cpu_wait), 64'd1);
      cyc(); smp();
      chk("R10 stable", 64'(m_data), 64'h0BADF00D);
      chk("R10 wait busy", 64'(cpu_wait), 64'd1);
      cyc(); m_ready = 1; smp();
      chk("R6 release on accept", 64'(cpu_wait), 64'd0);
      cyc(); smp();
      chk("R6 done", 64'(m_valid), 64'd0);

      // R8 fall with nothing held
      cyc(); tgt_stall = 1;
      cyc();
      cyc(); tgt_stall = 0;
      cyc(); smp();
      chk("R8 pulse", 64'(retry_clr), 64'd1);
      chk("R8 nothing sent", 64'(m_valid), 64'd0);
      cyc(); smp();
      chk("R8 still nothing", 64'(m_valid), 64'd0);

      // R9 write on the fall cycle
      cyc(); tgt_stall = 1;
      cyc();
      cyc(); tgt_stall = 0; drive_wr(30'h044, 32'h44440000, 4'hC); smp();
      chk("R9 fall accept", 64'(cpu_wait), 64'd0);
      cyc(); cpu_wr_valid = 0; smp();
      chk("R9 fall direct", 64'(m_data), 64'h44440000);
      chk("R9 fall valid", 64'(m_valid), 64'd1);
      // R9 write on the rising cycle
      cyc(); tgt_stall = 1; drive_wr(30'h055, 32'h55550000, 4'h1);
      cyc(); cpu_wr_valid = 0; smp();
      chk("R9 rise direct", 64'(m_data), 64'h55550000);
      chk("R9 rise valid", 64'(m_valid), 64'd1);
      cyc(); tgt_stall = 0;
      cyc();

      // random phase
      for (int c = 0; c < 6; c++) begin
         cyc(); cpu_wr_valid = 0; tgt_stall = 0; m_ready = 1;
         repeat (6) cyc();
         win_base = 11'($urandom);
         for (int k = 0; k < 2000; k++) begin
            cyc();
            if ($urandom % 12 == 0) tgt_stall = ~tgt_stall;
            m_ready = ($urandom % 10) < 7;
            if (!cpu_wr_valid || acc_last) begin
               if ($urandom % 3 != 0)
                  drive_wr(30'($urandom), $urandom, 4'($urandom));
               else
                  cpu_wr_valid = 0;
            end
         end
      end
      cyc(); cpu_wr_valid = 0; tgt_stall = 0; m_ready = 1;
      repeat (20) cyc();
      smp();
      chk("R12 all delivered", 64'(q_addr.size()), 64'd0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule